// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Buffer

This block sits on the transmit side of an isochronous IN endpoint in a USB device. Software loads payload bytes one at a time into a byte store that holds two packet slots. A slot is closed either when it reaches the full packet size or when software asks for a short packet through the control/status register. The serial engine sees the oldest closed slot as the head packet. It pulls that packet byte by byte, and the slot is freed as soon as its last byte has gone out.

The control/status register carries a room flag, a packet-sent flag that can raise an interrupt request, an underrun flag, a flush command and a short-packet command. The room flag is set while fewer than two packets are queued. The packet-sent flag is set by the engine and cleared by software writing 1. The underrun flag is set by the block and cleared by writing 1. When an IN token arrives while the packet-sent flag is still set and nothing is queued, the block answers with NAK.

Top module: `iso_in_txbuf`

## Requirements
- R1: After reset, `csr_rdata` reads 0x01: the room flag (bit 0) is 1 and every other bit is 0. `pkt_ready`, `irq` and `nak` are 0.
- R2: A slot becomes complete in either of two ways: when the PKT_BYTES-th byte is written to it, or when software writes 1 to bit 7 while the slot being filled holds at least one byte. A bit 7 write while the fill slot is empty has no effect.
- R3: Bit 0 (room flag, read-only) reads 1 while fewer than two complete packets are queued, and reads 0 when two are queued.
- R4: Bit 7 reads 1 while a short packet is queued. It returns to 0 once that packet has been read out.
- R5: `pkt_ready` is 1 while the head slot is complete, and `pkt_len` gives the byte count of the head slot. Each `rd_strobe` places the next byte on `rd_data` one cycle later, in the order the bytes were written. The last byte frees the slot, and the other slot then becomes the head.
- R6: A byte write that arrives while both slots are complete is dropped. Both packets then read out with their original lengths and contents.
- R7: If `rd_strobe` is asserted while no complete packet is at the head, `rd_data` returns 0x00 and bit 3 (underrun) is set. Writing 1 to bit 3 clears it. Writing 0 to bit 3 leaves it unchanged.
- R8: A `tx_done` pulse sets bit 1 (packet sent), and writing 1 to bit 1 clears it. `irq` equals `irq_en` AND bit 1.
- R9: `nak` is 1 in the cycle after an `in_token` pulse exactly when bit 1 was set and no complete packet was queued.
- R10: Writing 1 to bit 2 (flush) empties both slots and resets their byte counts. Bit 2 always reads 0.
- R11: Bits 6:4 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Control/status write data |
| csr_rdata | output | 8 | Control/status read value |
| fifo_wr | input | 1 | Software byte write strobe |
| fifo_wdata | input | 8 | Byte written into the fill slot |
| irq_en | input | 1 | Transmit interrupt enable |
| irq | output | 1 | Interrupt request |
| in_token | input | 1 | IN token pulse from the serial engine |
| nak | output | 1 | NAK response, one cycle after the token |
| tx_done | input | 1 | Engine pulse: packet delivered to host |
| pkt_ready | output | 1 | Head slot holds a complete packet |
| pkt_len | output | LEN_W | Byte count of the head slot |
| rd_strobe | input | 1 | Engine byte read request |
| rd_data | output | 8 | Byte returned one cycle after the read |

## Verification
The embedded assertions check several rules on every cycle. A dropped write must leave both byte counts stable. Flush must leave the block empty on the next cycle. A pending short packet must always imply a ready head. A packet-sent pulse, an underrun and a NAK condition must each show in the register or output one cycle later. Only the bench's scenarios can show the rest: byte ordering through both slots, release and hand-over of the head slot, the two ways a packet completes, the ignored short-packet request on an empty slot, and the interrupt gating by the enable.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

    // Control/status bit positions
    localparam int CSR_ROOM  = 0;
    localparam int CSR_SENT  = 1;
    localparam int CSR_FLUSH = 2;
    localparam int CSR_UNDR  = 3;
    localparam int CSR_SHORT = 7;

    typedef struct packed {
        logic full;
        logic shrt;
    } slot_flags_t;

    function automatic logic [7:0] pack_csr(input logic shrt, input logic undr,
                                            input logic sent, input logic room);
        logic [7:0] v;
        v = 8'h00;
        v[CSR_SHORT] = shrt;
        v[CSR_UNDR]  = undr;
        v[CSR_SENT]  = sent;
        v[CSR_ROOM]  = room;
        return v;
    endfunction

endpackage

// File: rtl/iso_tx_slots.sv
module iso_tx_slots
    import iso_tx_pkg::*;
#(
    parameter int PKT_BYTES = 256,
    localparam int LW = $clog2(PKT_BYTES + 1),
    localparam int PW = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_byte,
    input  logic          tsp_req,
    input  logic          flush,
    input  logic          rd_en,
    output logic [7:0]    rd_byte,
    output logic          pkt_ready,
    output logic [LW-1:0] pkt_len,
    output logic          underrun,
    output logic          room,
    output logic          tsp_pend
);

    slot_flags_t   fl_q   [2];
    logic [LW-1:0] cnt_q  [2];
    logic [7:0]    mem_q  [2][PKT_BYTES];
    logic          wsel_q, rsel_q;
    logic [PW-1:0] rpos_q;
    logic [7:0]    rd_byte_q;

    logic          wfull, head_full;
    logic [LW-1:0] wcnt, head_cnt;
    logic          wr_ok, wr_last, tsp_ok, rd_ok, rd_last;

    always_comb begin
        wfull     = fl_q[wsel_q].full;
        wcnt      = cnt_q[wsel_q];
        head_full = fl_q[rsel_q].full;
        head_cnt  = cnt_q[rsel_q];
        wr_ok     = wr_en && !wfull;
        wr_last   = wr_ok && (wcnt == LW'(PKT_BYTES - 1));
        // a byte write in the same cycle takes precedence over a short-packet request
        tsp_ok    = tsp_req && !wr_en && !wfull && (wcnt != '0);
        rd_ok     = rd_en && head_full;
        rd_last   = rd_ok && ((LW'(rpos_q) + LW'(1)) == head_cnt);
        underrun  = rd_en && !head_full;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < 2; i++) begin
                fl_q[i]  <= '0;
                cnt_q[i] <= '0;
            end
            wsel_q    <= 1'b0;
            rsel_q    <= 1'b0;
            rpos_q    <= '0;
            rd_byte_q <= 8'h00;
        end else begin
            if (wr_ok) begin
                cnt_q[wsel_q] <= wcnt + LW'(1);
                if (wr_last) begin
                    fl_q[wsel_q].full <= 1'b1;
                    wsel_q            <= ~wsel_q;
                end
            end else if (tsp_ok) begin
                fl_q[wsel_q] <= '{full: 1'b1, shrt: 1'b1};
                wsel_q       <= ~wsel_q;
            end
            if (rd_ok) begin
                rd_byte_q <= mem_q[rsel_q][rpos_q];
                if (rd_last) begin
                    fl_q[rsel_q]  <= '0;
                    cnt_q[rsel_q] <= '0;
                    rpos_q        <= '0;
                    rsel_q        <= ~rsel_q;
                end else begin
                    rpos_q <= rpos_q + PW'(1);
                end
            end else if (underrun) begin
                rd_byte_q <= 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && !flush && !rst)
            mem_q[wsel_q][wcnt[PW-1:0]] <= wr_byte;
    end

    assign rd_byte   = rd_byte_q;
    assign pkt_ready = head_full;
    assign pkt_len   = head_cnt;
    assign room      = !(fl_q[0].full && fl_q[1].full);
    assign tsp_pend  = (fl_q[0].full && fl_q[0].shrt) || (fl_q[1].full && fl_q[1].shrt);

    // R6
    no_drop_corrupt_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush && !rd_en && fl_q[0].full && fl_q[1].full)
        |=> ($stable(cnt_q[0]) && $stable(cnt_q[1])));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!pkt_ready && room && pkt_len == '0 && !tsp_pend));

    // R4
    short_implies_ready_chk: assert property (@(posedge clk) disable iff (rst)
        tsp_pend |-> pkt_ready);

endmodule

// File: rtl/iso_tx_csr.sv
module iso_tx_csr
    import iso_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       csr_wr,
    input  logic [7:0] csr_wdata,
    output logic [7:0] csr_rdata,
    input  logic       underrun,
    input  logic       tx_done,
    input  logic       in_token,
    input  logic       pkt_ready,
    input  logic       room,
    input  logic       tsp_pend,
    input  logic       irq_en,
    output logic       tsp_req,
    output logic       flush,
    output logic       irq,
    output logic       nak
);

    logic sent_q, undr_q, nak_q;
    logic unused_bits;

    assign unused_bits = ^{csr_wdata[6:4], csr_wdata[CSR_ROOM]};

    assign tsp_req = csr_wr && csr_wdata[CSR_SHORT];
    assign flush   = csr_wr && csr_wdata[CSR_FLUSH];

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q <= 1'b0;
            undr_q <= 1'b0;
            nak_q  <= 1'b0;
        end else begin
            if (tx_done)
                sent_q <= 1'b1;
            else if (csr_wr && csr_wdata[CSR_SENT])
                sent_q <= 1'b0;
            if (underrun)
                undr_q <= 1'b1;
            else if (csr_wr && csr_wdata[CSR_UNDR])
                undr_q <= 1'b0;
            nak_q <= in_token && sent_q && !pkt_ready;
        end
    end

    assign csr_rdata = pack_csr(tsp_pend, undr_q, sent_q, room);
    assign irq       = irq_en && sent_q;
    assign nak       = nak_q;

    // R8
    sent_sets_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> csr_rdata[CSR_SENT]);

    // R9
    nak_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (in_token && csr_rdata[CSR_SENT] && !pkt_ready) |=> nak);

    // R7
    underrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> csr_rdata[CSR_UNDR]);

    // R10
    flush_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[CSR_FLUSH] == 1'b0);

endmodule

// File: rtl/iso_in_txbuf.sv
module iso_in_txbuf
    import iso_tx_pkg::*;
#(
    parameter int PKT_BYTES = 256,
    localparam int LEN_W = $clog2(PKT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr,
    input  logic [7:0]       csr_wdata,
    output logic [7:0]       csr_rdata,
    input  logic             fifo_wr,
    input  logic [7:0]       fifo_wdata,
    input  logic             irq_en,
    output logic             irq,
    input  logic             in_token,
    output logic             nak,
    input  logic             tx_done,
    output logic             pkt_ready,
    output logic [LEN_W-1:0] pkt_len,
    input  logic             rd_strobe,
    output logic [7:0]       rd_data
);

    logic tsp_req, flush, underrun, room, tsp_pend;

    iso_tx_slots #(.PKT_BYTES(PKT_BYTES)) u_slots (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (fifo_wr),
        .wr_byte   (fifo_wdata),
        .tsp_req   (tsp_req),
        .flush     (flush),
        .rd_en     (rd_strobe),
        .rd_byte   (rd_data),
        .pkt_ready (pkt_ready),
        .pkt_len   (pkt_len),
        .underrun  (underrun),
        .room      (room),
        .tsp_pend  (tsp_pend)
    );

    iso_tx_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .underrun  (underrun),
        .tx_done   (tx_done),
        .in_token  (in_token),
        .pkt_ready (pkt_ready),
        .room      (room),
        .tsp_pend  (tsp_pend),
        .irq_en    (irq_en),
        .tsp_req   (tsp_req),
        .flush     (flush),
        .irq       (irq),
        .nak       (nak)
    );

endmodule

// File: tb/iso_in_txbuf_test.sv
module iso_in_txbuf_test;

    localparam int PB = 8;
    localparam int LW = $clog2(PB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csr_wr = 1'b0;
    logic [7:0]    csr_wdata = 8'h00;
    logic [7:0]    csr_rdata;
    logic          fifo_wr = 1'b0;
    logic [7:0]    fifo_wdata = 8'h00;
    logic          irq_en = 1'b0;
    logic          irq;
    logic          in_token = 1'b0;
    logic          nak;
    logic          tx_done = 1'b0;
    logic          pkt_ready;
    logic [LW-1:0] pkt_len;
    logic          rd_strobe = 1'b0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    iso_in_txbuf #(.PKT_BYTES(PB)) uut (.*);

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [7:0] nb;
        logic       tsp;
        logic       rdy;
        logic [3:0] len;
        logic       room;
        logic       shrt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd3,  1'b0, 1'b0, 4'd3, 1'b1, 1'b0},
        '{8'd3,  1'b1, 1'b1, 4'd3, 1'b1, 1'b1},
        '{8'd8,  1'b0, 1'b1, 4'd8, 1'b1, 1'b0},
        '{8'd16, 1'b0, 1'b1, 4'd8, 1'b0, 1'b0},
        '{8'd11, 1'b1, 1'b1, 4'd8, 1'b0, 1'b1},
        '{8'd0,  1'b1, 1'b0, 4'd0, 1'b1, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [7:0] v);
        csr_wr = 1'b1;
        csr_wdata = v;
        tick();
        csr_wr = 1'b0;
        csr_wdata = 8'h00;
    endtask

    task automatic push(input logic [7:0] b);
        fifo_wr = 1'b1;
        fifo_wdata = b;
        tick();
        fifo_wr = 1'b0;
    endtask

    task automatic pull(output logic [7:0] b);
        rd_strobe = 1'b1;
        tick();
        rd_strobe = 1'b0;
        b = rd_data;
    endtask

    task automatic token(output logic n);
        in_token = 1'b1;
        tick();
        in_token = 1'b0;
        n = nak;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic n;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 csr", 32'(csr_rdata), 32'h01);
        chk("R1 ready", 32'(pkt_ready), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 nak", 32'(nak), 0);

        // R2 R3 R4 R5 vector table
        foreach (VECS[i]) begin
            csr_write(8'h04);
            for (int k = 0; k < int'(VECS[i].nb); k++) push(8'(k));
            if (VECS[i].tsp) csr_write(8'h80);
            chk("R2 R5 ready", 32'(pkt_ready), 32'(VECS[i].rdy));
            chk("R5 len", 32'(pkt_len), 32'(VECS[i].len));
            chk("R3 room", 32'(csr_rdata[0]), 32'(VECS[i].room));
            chk("R4 short", 32'(csr_rdata[7]), 32'(VECS[i].shrt));
        end

        // R5 byte order and release
        csr_write(8'h04);
        for (int k = 0; k < PB; k++) push(8'hA0 + 8'(k));
        for (int k = 0; k < PB; k++) begin
            pull(b);
            chk("R5 data", 32'(b), 32'(8'hA0 + 8'(k)));
        end
        chk("R5 released", 32'(pkt_ready), 0);
        chk("R5 room", 32'(csr_rdata[0]), 1);

        // R6 drop when both full
        csr_write(8'h04);
        for (int k = 0; k < 2 * PB; k++) push(8'h10 + 8'(k));
        push(8'hEE);
        chk("R6 room", 32'(csr_rdata[0]), 0);
        for (int k = 0; k < 2 * PB; k++) begin
            if (k == 0 || k == PB) chk("R6 len", 32'(pkt_len), PB);
            pull(b);
            chk("R6 data", 32'(b), 32'(8'h10 + 8'(k)));
        end
        chk("R6 empty", 32'(pkt_ready), 0);

        // R4 short packet read out
        csr_write(8'h04);
        push(8'hC1); push(8'hC2);
        csr_write(8'h80);
        chk("R4 set", 32'(csr_rdata[7]), 1);
        pull(b); chk("R4 d0", 32'(b), 32'hC1);
        pull(b); chk("R4 d1", 32'(b), 32'hC2);
        chk("R4 cleared", 32'(csr_rdata[7]), 0);

        // R7 underrun
        csr_write(8'h04);
        pull(b);
        chk("R7 zero", 32'(b), 0);
        chk("R7 flag", 32'(csr_rdata[3]), 1);
        csr_write(8'h00);
        chk("R7 w0 keeps", 32'(csr_rdata[3]), 1);
        csr_write(8'h08);
        chk("R7 cleared", 32'(csr_rdata[3]), 0);

        // R8 packet sent and irq
        irq_en = 1'b1;
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        chk("R8 sent", 32'(csr_rdata[1]), 1);
        chk("R8 irq", 32'(irq), 1);
        irq_en = 1'b0; #1;
        chk("R8 irq gated", 32'(irq), 0);
        irq_en = 1'b1;

        // R9 nak
        token(n); chk("R9 nak idle", 32'(n), 1);
        tick(); chk("R9 nak drop", 32'(nak), 0);
        for (int k = 0; k < PB; k++) push(8'(k));
        token(n); chk("R9 no nak ready", 32'(n), 0);
        csr_write(8'h02);
        chk("R8 clear", 32'(csr_rdata[1]), 0);
        chk("R8 irq clear", 32'(irq), 0);
        csr_write(8'h04);
        token(n); chk("R9 no nak clear", 32'(n), 0);

        // R10 flush
        for (int k = 0; k < PB + 2; k++) push(8'(k));
        csr_write(8'h04);
        chk("R10 csr", 32'(csr_rdata), 32'h01);
        chk("R10 ready", 32'(pkt_ready), 0);
        chk("R10 len", 32'(pkt_len), 0);

        // R11 reserved bits
        csr_write(8'h70);
        chk("R11 reserved", 32'(csr_rdata), 32'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule